// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Memory

This block models a read-only configuration store that a programmable logic device pulls its bitstream from, one bit per clock. Every rising clock edge while the device is selected moves an internal bit pointer forward, and the bit under the pointer appears on a data output that is driven only when the device is selected and its reset/output-enable input sits at the enable level. That input is read through a stored polarity bit, so either sense of the board's reset line can be used without an inverter.

When the final stored bit has been shifted out, the pointer stops, the data driver turns off and a chip-enable-out output goes low. That output feeds the chip-enable of a second copy, which then continues the stream, so several copies chain into one longer bitstream. A serial-enable input switches the whole read path off. A small synchronous preload port, usable only in standby, fills the array and the polarity bit.

Top module: `cfg_bitstream_mem`

## Requirements
- R1: While enabled (ser_en high, ce_n low, reset input at its enable level) and not exhausted, data_oe is high and data_q shows stored bit k, where k counts the enabled clock edges since the last clear, starting at 0.
- R2: data_oe is high only when ser_en is high, ce_n is low, the reset input is at its enable level and the memory is not exhausted; data_q is 0 whenever data_oe is low.
- R3: When ser_en is high and the reset input is at its clear level, the next clock edge sets the pointer to bit 0 and clears the exhausted state, whether or not ce_n is low.
- R4: The clear level of rst_oe is high when the polarity bit is 0 and low when it is 1; the polarity bit takes pl_bit on a clock edge where pl_pol_we is high.
- R5: With ce_n high, the pointer holds and data_oe is low regardless of rst_oe.
- R6: The enabled edge that reads the last bit (index DEPTH-1) sets the exhausted state: from the next cycle data_oe is low and further edges neither move nor wrap the pointer until a clear.
- R7: While exhausted, ceo_n equals ce_n as long as the reset input is at its enable level; with the reset input at its clear level ceo_n is high, and after the clear it stays high until the whole memory has been read again.
- R8: With ser_en low, data_oe is low, ceo_n is high, the pointer does not move and the reset input has no effect.
- R9: Writes through pl_we and pl_pol_we take effect only on edges where ce_n is high; at other times they leave the array and the polarity bit unchanged.
- R10: A synchronous low rst_n clears the pointer, the exhausted state and the polarity bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial read clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low block reset |
| ser_en | input | 1 | High selects serial read operation |
| ce_n | input | 1 | Active-low chip enable; high means standby |
| rst_oe | input | 1 | Reset/output-enable input, sense set by the polarity bit |
| pl_we | input | 1 | Preload write strobe for one array bit |
| pl_addr | input | ADDR_W | Preload bit address |
| pl_bit | input | 1 | Preload data bit, also the polarity value |
| pl_pol_we | input | 1 | Preload write strobe for the polarity bit |
| data_q | output | 1 | Serial data, valid when data_oe is high |
| data_oe | output | 1 | Driver enable for the data pin (low means high impedance) |
| ceo_n | output | 1 | Active-low chip-enable-out for the next device in a chain |

## Verification
The assertions take for granted that every input is synchronous to clk and settles well away from its rising edge, that rst_n is low before the first edge, and that at most one chained device drives the shared data line at any time. The stimulus changes inputs only just after a falling edge and samples the outputs one nanosecond later, preloads the array only with ce_n high except in the one case meant to show a write being ignored, and chains two copies so the handoff from the first copy's last bit to the second copy's first bit is seen directly.

// File: rtl/cfgmem_pkg.sv
// Shared types and helpers for the serial configuration memory.
// Assumes nothing beyond a single clock domain.
package cfgmem_pkg;

    // Command from the pin control logic to the bit pointer.
    typedef struct packed {
        logic clr;   // return pointer to bit 0, leave exhausted state
        logic adv;   // move to the next bit
    } cnt_cmd_t;

    // True when the reset/output-enable pin is at its clear level.
    function automatic logic clear_level(input logic pin, input logic pol);
        return pin ^ pol;
    endfunction

endpackage

// File: rtl/cfgmem_array.sv
// Single-bit storage array with one synchronous write port and a
// combinational read port. Assumes the write strobe is already gated
// to standby by the caller. Contents are not reset.
module cfgmem_array #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);

    logic [DEPTH-1:0] cells;

    // Store one preload bit per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_bit;
        end
    end

    // Present the addressed bit.
    assign rd_bit = cells[rd_addr];

endmodule

// File: rtl/cfgmem_counter.sv
// Bit pointer with exhausted flag. Advances on adv, returns to 0 on
// clr, and stops at the last index instead of wrapping. Assumes clr
// and adv are never both meant to move the pointer (clr wins).
module cfgmem_counter
    import cfgmem_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cnt_cmd_t          cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    // Pointer and exhausted-state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            done <= 1'b0;
        end else if (cmd.clr) begin
            addr <= '0;
            done <= 1'b0;
        end else if (cmd.adv) begin
            if (addr == LAST) begin
                done <= 1'b1;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

    // R1
    advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.adv && !cmd.clr) |=> (addr == $past(addr) + 1'b1) || done);

    // R3
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.clr |=> (addr == '0) && !done);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd.adv && !cmd.clr) |=> $stable(addr) && $stable(done));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cmd.clr) |=> done && (addr == LAST));

endmodule

// File: rtl/cfgmem_ctrl.sv
// Pin control: holds the reset polarity bit, decodes the serial
// enable, chip enable and reset/output-enable pins into pointer
// commands, the data driver enable and the chip-enable-out pin.
// Assumes the pins are synchronous to clk.
module cfgmem_ctrl
    import cfgmem_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ser_en,
    input  logic     ce_n,
    input  logic     rst_oe,
    input  logic     pol_we,
    input  logic     pol_bit,
    input  logic     done,
    output cnt_cmd_t cmd,
    output logic     data_oe,
    output logic     ceo_n,
    output logic     standby
);

    logic pol;
    logic clr_lvl;
    logic enabled;

    // Polarity bit, writable only in standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol <= 1'b0;
        end else if (pol_we && ce_n) begin
            pol <= pol_bit;
        end
    end

    // Decode pins into enables and pointer commands.
    always_comb begin
        clr_lvl  = clear_level(rst_oe, pol);
        enabled  = ser_en && !ce_n && !clr_lvl;
        cmd.clr  = ser_en && clr_lvl;
        cmd.adv  = enabled && !done;
        data_oe  = enabled && !done;
        ceo_n    = !(enabled && done);
        standby  = ce_n;
    end

    // R2
    drive_handoff_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_oe && !ceo_n));

    // R7
    ceo_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.clr |=> ceo_n);

    // R8
    serial_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> (!data_oe && ceo_n && !cmd.adv && !cmd.clr));

    // R9
    pol_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |=> $stable(pol));

endmodule

// File: rtl/cfg_bitstream_mem.sv
// Cascadable serial configuration bit memory. One stored bit per
// enabled clock is presented on data_q with data_oe as the tri-state
// enable; after the last bit the driver turns off and ceo_n hands the
// stream to the next device. Assumes DEPTH is at least 2.
module cfg_bitstream_mem
    import cfgmem_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              ce_n,
    input  logic              rst_oe,
    input  logic              pl_we,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic              pl_bit,
    input  logic              pl_pol_we,
    output logic              data_q,
    output logic              data_oe,
    output logic              ceo_n
);

    cnt_cmd_t          cmd;
    logic [ADDR_W-1:0] addr;
    logic              done;
    logic              standby;
    logic              rd_bit;

    cfgmem_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_en  (ser_en),
        .ce_n    (ce_n),
        .rst_oe  (rst_oe),
        .pol_we  (pl_pol_we),
        .pol_bit (pl_bit),
        .done    (done),
        .cmd     (cmd),
        .data_oe (data_oe),
        .ceo_n   (ceo_n),
        .standby (standby)
    );

    cfgmem_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .addr  (addr),
        .done  (done)
    );

    cfgmem_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .wr_en   (pl_we && standby),
        .wr_addr (pl_addr),
        .wr_bit  (pl_bit),
        .rd_addr (addr),
        .rd_bit  (rd_bit)
    );

    // Drive data only while the output is enabled.
    assign data_q = data_oe && rd_bit;

    // R6
    handoff_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !data_oe);

    // R5
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!data_oe && ceo_n));

endmodule

// File: tb/cfg_bitstream_mem_bench.sv
// Two chained copies: the first copy's ceo_n drives the second copy's
// ce_n. Inputs change just after a falling edge, outputs are sampled
// 1 ns later.
module cfg_bitstream_mem_bench;

    localparam int DEPTH  = 16;
    localparam int ADDR_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en = 1'b1;
    logic ce_n = 1'b1;
    logic rst_oe = 1'b0;
    logic we0 = 1'b0;
    logic we1 = 1'b0;
    logic pol_we = 1'b0;
    logic [ADDR_W-1:0] pl_addr = '0;
    logic pl_bit = 1'b0;

    logic d0, oe0, ceo0_n, d1, oe1, ceo1_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cfg_bitstream_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cfg_bitstream_mem (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ce_n), .rst_oe(rst_oe),
        .pl_we(we0), .pl_addr(pl_addr), .pl_bit(pl_bit), .pl_pol_we(pol_we),
        .data_q(d0), .data_oe(oe0), .ceo_n(ceo0_n)
    );

    cfg_bitstream_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cfg_bitstream_mem_nxt (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ceo0_n), .rst_oe(rst_oe),
        .pl_we(we1), .pl_addr(pl_addr), .pl_bit(pl_bit), .pl_pol_we(pol_we),
        .data_q(d1), .data_oe(oe1), .ceo_n(ceo1_n)
    );

    // Stored pattern for device dev at bit i.
    function automatic logic pat(input int dev, input int i);
        return 1'(((i * 37 + dev * 11 + (i >> 2)) >> 1) & 1);
    endfunction

    // Fields: [7] ce_n, [6] rst_oe, [5] expected ceo0_n,
    // [4] expected drive of device 0, [3:0] expected bit index.
    localparam logic [7:0] VECS [0:9] = '{
        8'b0000_0000,   // exhausted, selected: ceo low
        8'b1010_0000,   // ce high: ceo follows
        8'b0000_0000,   // ce low again: ceo low
        8'b0110_0000,   // clear level: ceo high, pointer cleared
        8'b0011_0000,   // restart at bit 0
        8'b0011_0001,
        8'b1010_0000,   // standby holds pointer at 2
        8'b0011_0010,
        8'b1110_0000,   // clear while in standby
        8'b0011_0000
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        // R10: block reset
        repeat (3) nxt();
        #1;
        chk("R10", {6'd0, oe0, ceo0_n}, 8'b01);
        nxt();
        rst_n = 1'b1;

        // Preload both copies in standby.
        for (int i = 0; i < DEPTH; i++) begin
            we0 = 1'b1; pl_addr = ADDR_W'(i); pl_bit = pat(0, i);
            nxt();
        end
        we0 = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            we1 = 1'b1; pl_addr = ADDR_W'(i); pl_bit = pat(1, i);
            nxt();
        end
        we1 = 1'b0;

        // R3: clear level disables output, clears pointers
        ce_n = 1'b0; rst_oe = 1'b1;
        #1 chk("R3", {6'd0, oe0, oe1}, 8'b00);
        nxt();
        rst_oe = 1'b0;

        // R1: first copy streams its bits
        for (int k = 0; k < DEPTH; k++) begin
            #1 chk("R1", {4'd0, oe0, d0, ceo0_n, oe1}, {4'd0, 1'b1, pat(0, k), 1'b1, 1'b0});
            nxt();
        end
        // R6: handoff to the second copy
        #1 chk("R6", {5'd0, oe0, ceo0_n, oe1}, 8'b001);
        for (int k = 0; k < DEPTH; k++) begin
            #1 chk("R1", {5'd0, oe0, oe1, d1}, {5'd0, 1'b0, 1'b1, pat(1, k)});
            nxt();
        end
        // R7: second copy exhausted too
        #1 chk("R7", {4'd0, oe0, oe1, ceo0_n, ceo1_n}, 8'b0000);
        for (int k = 0; k < 3; k++) begin
            nxt();
            #1 chk("R6", {6'd0, oe0, oe1}, 8'b00);
        end

        // Table walk from the exhausted state.
        for (int v = 0; v < 10; v++) begin
            nxt();
            ce_n = VECS[v][7]; rst_oe = VECS[v][6];
            #1;
            chk("R7", {7'd0, ceo0_n}, {7'd0, VECS[v][5]});
            chk(VECS[v][7] ? "R5" : "R2", {6'd0, oe0, d0},
                {6'd0, VECS[v][4], VECS[v][4] & pat(0, int'(VECS[v][3:0]))});
        end

        // R9: preload while selected is ignored (pointer now at 1)
        nxt();
        we0 = 1'b1; pl_addr = 4'd1; pl_bit = ~pat(0, 1);
        #1 chk("R1", {6'd0, oe0, d0}, {6'd0, 1'b1, pat(0, 1)});
        nxt();
        we0 = 1'b0; rst_oe = 1'b1;
        nxt();
        rst_oe = 1'b0;
        #1 chk("R1", {6'd0, oe0, d0}, {6'd0, 1'b1, pat(0, 0)});
        nxt();
        #1 chk("R9", {6'd0, oe0, d0}, {6'd0, 1'b1, pat(0, 1)});

        // R8: serial enable low, clear level ignored (pointer at 2)
        nxt();
        ser_en = 1'b0; rst_oe = 1'b1;
        #1 chk("R8", {5'd0, oe0, ceo0_n, oe1}, 8'b010);
        nxt();
        ser_en = 1'b1; rst_oe = 1'b0;
        #1 chk("R8", {6'd0, oe0, d0}, {6'd0, 1'b1, pat(0, 2)});

        // R4: inverted polarity, written in standby
        nxt();
        ce_n = 1'b1; pol_we = 1'b1; pl_bit = 1'b1;
        nxt();
        pol_we = 1'b0; ce_n = 1'b0; rst_oe = 1'b0;
        #1 chk("R4", {6'd0, oe0, ceo0_n}, 8'b01);
        nxt();
        rst_oe = 1'b1;
        #1 chk("R4", {6'd0, oe0, d0}, {6'd0, 1'b1, pat(0, 0)});
        nxt();
        #1 chk("R4", {6'd0, oe0, d0}, {6'd0, 1'b1, pat(0, 1)});

        // R9: polarity write while selected is ignored
        nxt();
        pol_we = 1'b1; pl_bit = 1'b0;
        #1 chk("R1", {6'd0, oe0, d0}, {6'd0, 1'b1, pat(0, 2)});
        nxt();
        pol_we = 1'b0;
        #1 chk("R9", {6'd0, oe0, d0}, {6'd0, 1'b1, pat(0, 3)});

        // R10: block reset returns polarity to 0
        nxt();
        rst_n = 1'b0;
        nxt();
        rst_n = 1'b1;
        #1 chk("R10", {6'd0, oe0, ceo0_n}, 8'b01);

        nxt();
        finished = 1'b1;
        finish_run();
    end

endmodule